// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block links two open-drain data lines, one on the host side and one on the card side, so that either party can signal the other through it. Both lines rest high through external passive pull-ups while nothing happens. When one side pulls its line low first, that side becomes the master for the transfer. After a fixed delay the repeater copies the low level onto the other side, which is the slave. While the transfer lasts, falling edges on the slave line are not looked at.

When the master lets its line go high again, the repeater releases the slave's pull-low. It then drives the slave line high actively for a fixed number of cycles, which speeds up the rising edge. After that both sides go back to idle. For each side the block takes a sampled line level. For each side it gives a pull-low enable and a drive-high enable, which steer external pad drivers. One instance serves one line, so a reader with a data line and two auxiliary lines uses three instances. Both delays are counted in system-clock cycles and are set by parameters. They should stay well below the 500 ns half-period of a 1 MHz line.

Top module: `odr_repeater`

## Requirements
- R1: After reset, and whenever no transfer is in progress, all four enables (host_pull_lo, host_drive_hi, card_pull_lo, card_drive_hi) are 0.
- R2: If host_in is first sampled low at clock edge N, while card_in stays high and the block is idle and enabled, card_pull_lo goes to 1 after edge N+EDGE_DLY+2 and not earlier. The host side is never driven during the transfer.
- R3: The same holds with the sides swapped: if card_in falls first, host_pull_lo goes to 1 after edge N+EDGE_DLY+2, and the card side is never driven.
- R4: Once a master is chosen, a falling edge on the slave-side input does not change the master, and it does not make the repeater drive the master side.
- R5: If the master's input is first sampled high at edge M while the slave is being pulled low, then after edge M+2 the slave pull-low is 0 and the slave drive-high is 1. Drive-high stays 1 for exactly PU_TIME cycles, and then all enables are 0.
- R6: If both inputs are first sampled low at the same edge, the card side becomes master and host_pull_lo is asserted with the timing of R3.
- R7: If the master's input returns high before the edge delay has run out, the transfer is dropped. Neither side is pulled low or driven high.
- R8: While en is 0, all four enables are 0 in the same cycle, and any transfer in progress is abandoned. After en returns to 1 with both lines high, the block stays idle.
- R9: No side has its pull-low and drive-high enables at 1 together. At most one side is driven by the repeater at any time.
- R10: After the pull-up period ends, a new falling edge on either line starts a new transfer with the timing of R2 or R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; 0 forces idle |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_pull_lo | output | 1 | Turns on the host-side pull-low driver |
| host_drive_hi | output | 1 | Turns on the host-side active high driver |
| card_pull_lo | output | 1 | Turns on the card-side pull-low driver |
| card_drive_hi | output | 1 | Turns on the card-side active high driver |

## Verification
The properties assume that the lines follow the repeater's own drivers, that is, a side the repeater pulls low reads low. They also assume that no party holds the slave line low when the master releases its line, since that would fight the active high drive. The bench models each line as the wired-AND of an external pull-low and the repeater's pull-low. The bench always releases any external low on the slave side before the master releases its line. All edges are applied half a period away from the sampling clock edge, so the cycle counts in R2, R3 and R5 are measured exactly.

// File: rtl/odr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the open-drain line repeater.
// Assumes side index 0 is the host line and index 1 is the card line.
package odr_pkg;

    // Number of line sides handled by one repeater.
    localparam int NUM_SIDES = 2;

    // Side index encoding.
    localparam int SIDE_HOST = 0;
    localparam int SIDE_CARD = 1;

    // Transfer state of the arbiter.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // nothing driven, waiting for a falling edge
        ST_DELAY  = 2'd1,  // master chosen, edge delay running
        ST_HOLD   = 2'd2,  // slave side pulled low
        ST_PULLUP = 2'd3   // slave side actively driven high
    } odr_state_e;

endpackage

// File: rtl/odr_sync.sv
`timescale 1ns/1ps
// Module: odr_sync
// Brings one asynchronous line level into the clock domain through a
// chain of STAGES flops. Keeps the previous synchronized level and flags
// a high-to-low transition. Assumes the line rests high, so every flop
// resets to 1 and no false edge is reported after reset.
module odr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // First synchronizer stage samples the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= line_in;
    end

    // Remaining stages shift the level along the chain.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    // Expose level and falling edge.
    always_comb begin
        level = chain[STAGES-1];
        fall  = prev & ~chain[STAGES-1];
    end

endmodule

// File: rtl/odr_timer.sv
`timescale 1ns/1ps
// Module: odr_timer
// Down-counter shared by the edge delay and the pull-up period. A load
// sets the start value; the counter then decrements to zero and holds.
// Assumes the caller loads value-1 for a window of value cycles.
module odr_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Zero marks the end of the running window.
    always_comb done = (cnt == '0);

endmodule

// File: rtl/odr_ctrl.sv
`timescale 1ns/1ps
// Module: odr_ctrl
// Arbitration and sequencing for one line. The first side with a
// falling edge becomes master; the card side wins a tie. Only the
// master's level is watched until the transfer ends, so slave edges
// are locked out. Assumes the timer windows are loaded on state entry.
module odr_ctrl
    import odr_pkg::*;
#(
    parameter int W        = 3,
    parameter int DLY_LOAD = 2,
    parameter int PU_LOAD  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [NUM_SIDES-1:0] level,
    input  logic [NUM_SIDES-1:0] fall,
    input  logic                 tmr_done,
    output logic                 tmr_load,
    output logic [W-1:0]         tmr_val,
    output odr_state_e           state,
    output logic                 master
);

    odr_state_e state_nx;
    logic       master_nx;
    logic       master_lvl;

    // Level of the side that currently owns the line.
    always_comb master_lvl = level[master];

    // Next-state and timer-load decision.
    always_comb begin
        state_nx  = state;
        master_nx = master;
        tmr_load  = 1'b0;
        tmr_val   = W'(DLY_LOAD);
        unique case (state)
            ST_IDLE: begin
                if (fall[SIDE_CARD]) begin
                    state_nx  = ST_DELAY;
                    master_nx = 1'b1;
                    tmr_load  = 1'b1;
                end else if (fall[SIDE_HOST]) begin
                    state_nx  = ST_DELAY;
                    master_nx = 1'b0;
                    tmr_load  = 1'b1;
                end
            end
            ST_DELAY: begin
                if (master_lvl)    state_nx = ST_IDLE;
                else if (tmr_done) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (master_lvl) begin
                    state_nx = ST_PULLUP;
                    tmr_load = 1'b1;
                    tmr_val  = W'(PU_LOAD);
                end
            end
            ST_PULLUP: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register; disable drops any transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state  <= ST_IDLE;
            master <= 1'b0;
        end else begin
            state  <= state_nx;
            master <= master_nx;
        end
    end

endmodule

// File: rtl/odr_repeater.sv
`timescale 1ns/1ps
// Module: odr_repeater (top)
// Bidirectional open-drain repeater for one line. Synchronizes both
// line inputs, arbitrates the master and decodes per-side pull-low and
// drive-high enables from the transfer state. Assumes external passive
// pull-ups and pad drivers; EDGE_DLY and PU_TIME are at least 1.
module odr_repeater
    import odr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_DLY    = 3,
    parameter int PU_TIME     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic host_in,
    input  logic card_in,
    output logic host_pull_lo,
    output logic host_drive_hi,
    output logic card_pull_lo,
    output logic card_drive_hi
);

    localparam int MAX_CNT = (EDGE_DLY > PU_TIME) ? EDGE_DLY : PU_TIME;
    localparam int CW      = $clog2(MAX_CNT + 1);

    logic [NUM_SIDES-1:0] line_raw;
    logic [NUM_SIDES-1:0] level;
    logic [NUM_SIDES-1:0] fall;
    logic [NUM_SIDES-1:0] pull_lo;
    logic [NUM_SIDES-1:0] drive_hi;
    logic                 tmr_load;
    logic [CW-1:0]        tmr_val;
    logic                 tmr_done;
    logic                 master;
    odr_state_e           state;

    // Gather the line inputs by side index.
    always_comb begin
        line_raw[SIDE_HOST] = host_in;
        line_raw[SIDE_CARD] = card_in;
    end

    // One synchronizer and enable decoder per side.
    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            odr_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_in (line_raw[s]),
                .level   (level[s]),
                .fall    (fall[s])
            );

            // Drive only the non-master side, only while enabled.
            always_comb begin
                pull_lo[s]  = en && (state == ST_HOLD)   && (int'(master) != s);
                drive_hi[s] = en && (state == ST_PULLUP) && (int'(master) != s);
            end
        end
    endgenerate

    odr_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    odr_ctrl #(
        .W        (CW),
        .DLY_LOAD (EDGE_DLY - 1),
        .PU_LOAD  (PU_TIME - 1)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .level    (level),
        .fall     (fall),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state    (state),
        .master   (master)
    );

    // Map the per-side enables to the ports.
    always_comb begin
        host_pull_lo  = pull_lo[SIDE_HOST];
        host_drive_hi = drive_hi[SIDE_HOST];
        card_pull_lo  = pull_lo[SIDE_CARD];
        card_drive_hi = drive_hi[SIDE_CARD];
    end

endmodule

// File: rtl/odr_repeater_chk.sv
`timescale 1ns/1ps
// Module: odr_repeater_chk
// Port-level properties of the repeater, bound to every instance.
// Assumes the lines follow the repeater's drivers and that nobody holds
// the slave line low when the master releases.
module odr_repeater_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic host_pull_lo,
    input logic host_drive_hi,
    input logic card_pull_lo,
    input logic card_drive_hi
);

    // R9: one side never pulls low and drives high together.
    assert_host_no_fight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_pull_lo && host_drive_hi));
    assert_card_no_fight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_pull_lo && card_drive_hi));

    // R9: at most one side is driven by the repeater.
    assert_one_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({host_pull_lo | host_drive_hi, card_pull_lo | card_drive_hi}) <= 1);

    // R8: disabled means nothing driven.
    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(host_pull_lo || host_drive_hi || card_pull_lo || card_drive_hi));

    // R5: releasing a pull-low while enabled hands over to the high driver.
    assert_card_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(card_pull_lo) && en) |-> card_drive_hi);
    assert_host_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_pull_lo) && en) |-> host_drive_hi);

    // R2: a new pull-low starts from a cycle with nothing driven.
    assert_card_pull_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pull_lo) |-> $past(!card_drive_hi && !host_pull_lo && !host_drive_hi));
    // R3: same for the host side.
    assert_host_pull_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_pull_lo) |-> $past(!host_drive_hi && !card_pull_lo && !card_drive_hi));

endmodule

bind odr_repeater odr_repeater_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .host_pull_lo  (host_pull_lo),
    .host_drive_hi (host_drive_hi),
    .card_pull_lo  (card_pull_lo),
    .card_drive_hi (card_drive_hi)
);

// File: tb/odr_repeater_tb.sv
`timescale 1ns/1ps
// Bench for odr_repeater: vector table of transfers, then directed cases.
module odr_repeater_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EDGE_DLY   = 3;
    localparam int PU_TIME    = 4;
    localparam int LAT_LO     = EDGE_DLY + 3;  // edge index after N+EDGE_DLY+2
    localparam int LAT_HI     = 3;             // edge index after M+2

    // Vector: {side[1:0] 0=host 1=card 2=both, extra hold cycles[5:0]}
    localparam int NVEC = 6;
    localparam logic [7:0] VECS [NVEC] = '{
        {2'd0, 6'd0}, {2'd1, 6'd2}, {2'd0, 6'd7},
        {2'd2, 6'd1}, {2'd1, 6'd5}, {2'd2, 6'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic host_ext_lo = 1'b0;
    logic card_ext_lo = 1'b0;
    logic host_in, card_in;
    logic host_pull_lo, host_drive_hi, card_pull_lo, card_drive_hi;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    assign host_in = ~(host_ext_lo | host_pull_lo);
    assign card_in = ~(card_ext_lo | card_pull_lo);

    always #(CLK_PERIOD/2) clk = ~clk;

    odr_repeater #(.EDGE_DLY(EDGE_DLY), .PU_TIME(PU_TIME)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .host_in(host_in), .card_in(card_in),
        .host_pull_lo(host_pull_lo), .host_drive_hi(host_drive_hi),
        .card_pull_lo(card_pull_lo), .card_drive_hi(card_drive_hi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int drv_bits();
        return {host_pull_lo, host_drive_hi, card_pull_lo, card_drive_hi};
    endfunction

    // Master side index: 0 host, 1 card.
    function automatic logic slave_lo(input int m);
        return (m == 1) ? host_pull_lo : card_pull_lo;
    endfunction
    function automatic logic slave_hi(input int m);
        return (m == 1) ? host_drive_hi : card_drive_hi;
    endfunction
    function automatic logic master_drv(input int m);
        return (m == 1) ? (card_pull_lo | card_drive_hi) : (host_pull_lo | host_drive_hi);
    endfunction

    // One full transfer; side 2 means both fall together (card wins, R6).
    task automatic transfer(input int side, input int hold, input string req);
        int m = (side == 0) ? 0 : 1;
        int k = 0;
        int hi_len = 1;
        bit mdrv = 1'b0;
        @(negedge clk);
        host_ext_lo = (side != 1);
        card_ext_lo = (side != 0);
        while (k < 40 && !slave_lo(m)) begin
            @(posedge clk); #1;
            k++;
            if (master_drv(m)) mdrv = 1'b1;
        end
        check(k == LAT_LO, {req, " pull-low latency"}, k, LAT_LO);
        repeat (hold) begin
            @(posedge clk); #1;
            if (master_drv(m) || !slave_lo(m)) mdrv = 1'b1;
        end
        check(!mdrv, {req, " master side undriven, slave held"}, int'(mdrv), 0);
        @(negedge clk);
        host_ext_lo = 1'b0;
        card_ext_lo = 1'b0;
        k = 0;
        while (k < 40 && !slave_hi(m)) begin
            @(posedge clk); #1;
            k++;
        end
        check(k == LAT_HI && !slave_lo(m), "R5 drive-high latency", k, LAT_HI);
        forever begin
            @(posedge clk); #1;
            if (!slave_hi(m)) break;
            hi_len++;
        end
        check(hi_len == PU_TIME, "R5 drive-high length", hi_len, PU_TIME);
        check(drv_bits() == 0, "R1 idle after transfer", drv_bits(), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1;
        check(drv_bits() == 0, "R1 enables during reset", drv_bits(), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check(drv_bits() == 0, "R1 idle after reset", drv_bits(), 0);

        // Table walk: host (R2), card (R3), both (R6), back-to-back (R10).
        for (int i = 0; i < NVEC; i++) begin
            int sd = int'(VECS[i][7:6]);
            transfer(sd, int'(VECS[i][5:0]),
                     (sd == 0) ? "R2" : (sd == 1) ? "R3" : "R6");
        end
        // R10: immediate restart right after a pull-up window.
        transfer(0, 0, "R10");

        // R7: master low for only two sampled cycles, dropped in delay.
        @(negedge clk); host_ext_lo = 1'b1;
        @(negedge clk); @(negedge clk); host_ext_lo = 1'b0;
        cnt = 0;
        repeat (15) begin
            @(posedge clk); #1;
            if (drv_bits() != 0) cnt++;
        end
        check(cnt == 0, "R7 short pulse not propagated", cnt, 0);

        // R4: card falls one cycle after host; host stays master.
        @(negedge clk); host_ext_lo = 1'b1;
        @(negedge clk); card_ext_lo = 1'b1;
        cnt = 0;
        repeat (LAT_LO + 2) begin
            @(posedge clk); #1;
            if (host_pull_lo || host_drive_hi) cnt++;
        end
        check(cnt == 0 && card_pull_lo, "R4 slave edge locked out", cnt, 0);
        @(negedge clk); card_ext_lo = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(card_pull_lo && !host_pull_lo, "R4 slave still held", drv_bits(), 2);
        @(negedge clk); host_ext_lo = 1'b0;
        repeat (LAT_HI) @(posedge clk);
        #1;
        check(card_drive_hi && !host_pull_lo, "R4 R5 release to card", drv_bits(), 1);
        repeat (PU_TIME + 6) @(posedge clk);
        #1;
        check(drv_bits() == 0, "R4 idle after", drv_bits(), 0);

        // R8: disable mid-transfer.
        @(negedge clk); host_ext_lo = 1'b1;
        repeat (LAT_LO + 1) @(posedge clk);
        @(negedge clk);
        check(card_pull_lo, "R8 transfer active before disable", int'(card_pull_lo), 1);
        en = 1'b0;
        #1;
        check(drv_bits() == 0, "R8 disable clears enables", drv_bits(), 0);
        repeat (3) @(posedge clk);
        @(negedge clk); host_ext_lo = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); en = 1'b1;
        cnt = 0;
        repeat (12) begin
            @(posedge clk); #1;
            if (drv_bits() != 0) cnt++;
        end
        check(cnt == 0, "R8 idle after re-enable", cnt, 0);
        transfer(1, 1, "R8 R3 after re-enable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule